// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps one reservation per core for a multi-core system that builds atomic read-modify-write sequences from a load-linked followed by a store-conditional. When a core issues a load-linked, the block records the cache-block address the core read. Before the paired store-conditional arrives, any event that could break the illusion of atomicity clears that record:

- an invalidation of the block seen on the snoop port that another core caused;
- a successful store-conditional by another core to the same block;
- the core's own store-conditional.

The block decides each store-conditional. The result comes back one cycle after the request, together with a write enable for the memory side. A store that loses its reservation is cancelled rather than performed, so no locked bus transaction is needed.

Each core owns one link slot, a two-state machine with states `LINK_EMPTY` and `LINK_HELD`:

- **EMPTY->HELD (arm):** taken on a load-linked.
- **HELD->HELD (re-arm):** a new load-linked replaces the recorded block.
- **HELD->EMPTY (consume):** taken on the core's own store-conditional.
- **HELD->EMPTY (lose):** taken on a matching invalidation from another core, or on another core's winning store-conditional to the same block.
- **EMPTY->EMPTY (idle):** taken on every other input.

Addresses are compared at block granularity: the low `OFF_W` offset bits are ignored.

Top module: `llsc_reservation_monitor`

## Requirements
- R1: While reset is asserted and immediately after it, every `sc_done`, `sc_ok` and `mem_we` bit is 0 and every link slot is empty, so a store-conditional issued first after reset fails.
- R2: A load-linked (`req_valid[i]`=1, `req_is_sc[i]`=0) records block `req_addr[i][ADDR_W-1:OFF_W]` for core i. A later store-conditional by core i to any address within that block (any offset bits) succeeds if nothing cleared the link.
- R3: A store-conditional request (`req_valid[i]`=1, `req_is_sc[i]`=1) in cycle t makes `sc_done[i]`=1 in cycle t+1 only. `sc_ok[i]` then reads 1 for success and 0 for failure. A load-linked or an idle cycle gives `sc_done[i]`=0.
- R4: A store-conditional fails when core i holds no link, or when its block differs from the linked block.
- R5: `mem_we[i]` is 1 exactly in the cycle where `sc_ok[i]` reports success. A failed store-conditional never raises `mem_we[i]`.
- R6: Every store-conditional, successful or not, empties the issuing core's link. A second store-conditional without a new load-linked fails.
- R7: A snoop (`snp_valid`=1) from core `snp_src` to the linked block of core i, with `snp_src` not equal to i, empties core i's link. A store-conditional by core i in the same cycle fails. A snoop from core i itself, or to another block, leaves the link intact.
- R8: A successful store-conditional by core j empties the link of every other core linked to the same block.
- R9: Among store-conditionals to one block that are eligible in the same cycle, only the lowest-indexed core succeeds. The others fail.
- R10: A load-linked in the same cycle as a clearing event for the same block leaves the core's link held on the new block.
- R11: A new load-linked replaces the previous link. A store-conditional to the old block then fails, and one to the new block succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_CORES | Per-core request present |
| req_is_sc | input | NUM_CORES | Per-core request kind: 1 store-conditional, 0 load-linked |
| req_addr | input | NUM_CORES*ADDR_W | Per-core request address, core i in bits [i*ADDR_W +: ADDR_W] |
| snp_valid | input | 1 | Snooped invalidation present |
| snp_addr | input | ADDR_W | Address of the invalidated block |
| snp_src | input | CORE_W | Index of the core that caused the invalidation |
| sc_done | output | NUM_CORES | Store-conditional result valid, one cycle after the request |
| sc_ok | output | NUM_CORES | Result: 1 success, 0 failure |
| mem_we | output | NUM_CORES | Memory write enable for a successful store-conditional |

## Verification
The link slots are hidden, so a wrong slot state shows only at the ports. It appears on the first store-conditional that core issues afterwards: `sc_ok` and `mem_we` come out flipped one cycle after that request. A clearing event that is missed or applied to the wrong core stays invisible until the affected core tries to store. For that reason the stimulus pairs every kind of clearing event with a store-conditional by the victim core soon after. It also checks the result on every clock against a behavioural model of the reservation table, so a divergence is caught at the first store that depends on it.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    typedef enum logic {
        LINK_EMPTY = 1'b0,
        LINK_HELD  = 1'b1
    } link_state_e;
endpackage

// File: rtl/llsc_link_slot.sv
module llsc_link_slot
    import llsc_pkg::*;
#(
    parameter int BLK_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ll_set,
    input  logic             sc_clear,
    input  logic             kill,
    input  logic [BLK_W-1:0] set_blk,
    output logic             held,
    output logic [BLK_W-1:0] blk
);
    link_state_e      state_q, state_d;
    logic [BLK_W-1:0] blk_q, blk_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LINK_EMPTY;
            blk_q   <= '0;
        end else begin
            state_q <= state_d;
            blk_q   <= blk_d;
        end
    end

    // transitions: arm, re-arm, consume, lose, idle
    always_comb begin
        state_d = state_q;
        blk_d   = blk_q;
        unique case (state_q)
            LINK_EMPTY: begin
                if (ll_set) begin
                    state_d = LINK_HELD;
                    blk_d   = set_blk;
                end
            end
            LINK_HELD: begin
                if (ll_set) begin
                    blk_d = set_blk;
                end else if (sc_clear || kill) begin
                    state_d = LINK_EMPTY;
                end
            end
            default: state_d = LINK_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        held = (state_q == LINK_HELD);
        blk  = blk_q;
    end

    // R6
    sc_empties_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_clear |=> !held);
    // R10
    ll_arms_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ll_set |=> (held && blk == $past(set_blk)));
    // R7
    kill_empties_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && kill && !ll_set) |=> !held);
endmodule

// File: rtl/llsc_sc_arbiter.sv
module llsc_sc_arbiter #(
    parameter int NUM_CORES = 4,
    parameter int BLK_W     = 26,
    parameter int CORE_W    = 2
) (
    input  logic [NUM_CORES-1:0]            sc_req,
    input  logic [NUM_CORES-1:0][BLK_W-1:0] req_blk,
    input  logic [NUM_CORES-1:0]            held,
    input  logic [NUM_CORES-1:0][BLK_W-1:0] link_blk,
    input  logic                            snp_valid,
    input  logic [BLK_W-1:0]                snp_blk,
    input  logic [CORE_W-1:0]               snp_src,
    output logic [NUM_CORES-1:0]            win,
    output logic [NUM_CORES-1:0]            kill
);
    logic [NUM_CORES-1:0] snp_hit;
    logic [NUM_CORES-1:0] cand;

    always_comb begin
        for (int i = 0; i < NUM_CORES; i++) begin
            snp_hit[i] = snp_valid && (snp_src != CORE_W'(i)) &&
                         (snp_blk == link_blk[i]);
            cand[i]    = sc_req[i] && held[i] &&
                         (link_blk[i] == req_blk[i]) && !snp_hit[i];
        end
    end

    // lowest index wins per block
    always_comb begin
        for (int i = 0; i < NUM_CORES; i++) begin
            win[i] = cand[i];
            for (int j = 0; j < i; j++) begin
                if (cand[j] && (req_blk[j] == req_blk[i])) win[i] = 1'b0;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_CORES; i++) begin
            kill[i] = snp_hit[i];
            for (int j = 0; j < NUM_CORES; j++) begin
                if (j != i && win[j] && (req_blk[j] == link_blk[i])) kill[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/llsc_result_reg.sv
module llsc_result_reg #(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] sc_req,
    input  logic [NUM_CORES-1:0] win,
    output logic [NUM_CORES-1:0] sc_done,
    output logic [NUM_CORES-1:0] sc_ok,
    output logic [NUM_CORES-1:0] mem_we
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_done <= '0;
            sc_ok   <= '0;
            mem_we  <= '0;
        end else begin
            sc_done <= sc_req;
            sc_ok   <= win;
            mem_we  <= win;
        end
    end
endmodule

// File: rtl/llsc_reservation_monitor.sv
module llsc_reservation_monitor #(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 6,
    parameter int CORE_W    = $clog2(NUM_CORES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CORES-1:0]          req_valid,
    input  logic [NUM_CORES-1:0]          req_is_sc,
    input  logic [NUM_CORES*ADDR_W-1:0]   req_addr,
    input  logic                          snp_valid,
    input  logic [ADDR_W-1:0]             snp_addr,
    input  logic [CORE_W-1:0]             snp_src,
    output logic [NUM_CORES-1:0]          sc_done,
    output logic [NUM_CORES-1:0]          sc_ok,
    output logic [NUM_CORES-1:0]          mem_we
);
    localparam int BLK_W = ADDR_W - OFF_W;

    logic [NUM_CORES-1:0][BLK_W-1:0] req_blk;
    logic [NUM_CORES-1:0][BLK_W-1:0] link_blk;
    logic [NUM_CORES-1:0]            held, ll_req, sc_req, win, kill, off_par;
    logic [BLK_W-1:0]                snp_blk;
    logic                            unused_off_bits;

    assign snp_blk = snp_addr[ADDR_W-1:OFF_W];

    generate
        for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
            assign req_blk[g] = req_addr[g*ADDR_W + OFF_W +: BLK_W];
            assign off_par[g] = ^req_addr[g*ADDR_W +: OFF_W];
            assign ll_req[g]  = req_valid[g] && !req_is_sc[g];
            assign sc_req[g]  = req_valid[g] && req_is_sc[g];

            llsc_link_slot #(.BLK_W(BLK_W)) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .ll_set   (ll_req[g]),
                .sc_clear (sc_req[g]),
                .kill     (kill[g]),
                .set_blk  (req_blk[g]),
                .held     (held[g]),
                .blk      (link_blk[g])
            );

            // R3
            sc_result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sc_req[g] |=> sc_done[g]);
            // R3
            no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !sc_req[g] |=> !sc_done[g]);
            // R4
            ok_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sc_ok[g] |-> $past(held[g]));
            // R5
            we_only_on_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
                mem_we[g] |-> (sc_ok[g] && sc_done[g]));

            for (genvar h = g + 1; h < NUM_CORES; h++) begin : g_pair
                // R9
                single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    !(win[g] && win[h] && req_blk[g] == req_blk[h]));
            end
        end
    endgenerate

    assign unused_off_bits = ^{off_par, snp_addr[OFF_W-1:0]};

    llsc_sc_arbiter #(
        .NUM_CORES (NUM_CORES),
        .BLK_W     (BLK_W),
        .CORE_W    (CORE_W)
    ) u_arb (
        .sc_req    (sc_req),
        .req_blk   (req_blk),
        .held      (held),
        .link_blk  (link_blk),
        .snp_valid (snp_valid),
        .snp_blk   (snp_blk),
        .snp_src   (snp_src),
        .win       (win),
        .kill      (kill)
    );

    llsc_result_reg #(.NUM_CORES(NUM_CORES)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .sc_req  (sc_req),
        .win     (win),
        .sc_done (sc_done),
        .sc_ok   (sc_ok),
        .mem_we  (mem_we)
    );
endmodule

// File: tb/tb_llsc_reservation_monitor.sv
module tb_llsc_reservation_monitor;
    localparam int N  = 4;
    localparam int AW = 32;
    localparam int OW = 6;
    localparam int CW = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst_n;
    logic [N-1:0]    req_valid, req_is_sc;
    logic [N*AW-1:0] req_addr;
    logic            snp_valid;
    logic [AW-1:0]   snp_addr;
    logic [CW-1:0]   snp_src;
    logic [N-1:0]    sc_done, sc_ok, mem_we;

    int vectors = 0;
    int errors  = 0;
    bit mv[N];
    int mb[N];

    llsc_reservation_monitor #(.NUM_CORES(N), .ADDR_W(AW), .OFF_W(OW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_sc(req_is_sc),
        .req_addr(req_addr), .snp_valid(snp_valid), .snp_addr(snp_addr),
        .snp_src(snp_src), .sc_done(sc_done), .sc_ok(sc_ok), .mem_we(mem_we)
    );

    task automatic clr();
        req_valid = '0; req_is_sc = '0; req_addr = '0;
        snp_valid = 1'b0; snp_addr = '0; snp_src = '0;
    endtask

    task automatic ll(input int c, input logic [AW-1:0] a);
        req_valid[c] = 1'b1; req_is_sc[c] = 1'b0; req_addr[c*AW +: AW] = a;
    endtask

    task automatic sc(input int c, input logic [AW-1:0] a);
        req_valid[c] = 1'b1; req_is_sc[c] = 1'b1; req_addr[c*AW +: AW] = a;
    endtask

    task automatic snoop(input int s, input logic [AW-1:0] a);
        snp_valid = 1'b1; snp_src = CW'(s); snp_addr = a;
    endtask

    task automatic check(input string tag, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // apply current inputs for one clock, predict, compare
    task automatic step(input string tag);
        logic [N-1:0] e_done, e_ok;
        bit hit[N];
        bit wn[N];
        int rb[N];
        int claimed[$];
        int sb;
        sb = int'(snp_addr >> OW);
        e_done = '0; e_ok = '0;
        for (int i = 0; i < N; i++) begin
            rb[i]  = int'(req_addr[i*AW +: AW] >> OW);
            hit[i] = snp_valid && (int'(snp_src) != i) && mv[i] && (mb[i] == sb);
        end
        for (int i = 0; i < N; i++) begin
            bit taken;
            wn[i] = 1'b0;
            if (req_valid[i] && req_is_sc[i]) begin
                e_done[i] = 1'b1;
                taken = 1'b0;
                foreach (claimed[k]) if (claimed[k] == rb[i]) taken = 1'b1;
                if (mv[i] && mb[i] == rb[i] && !hit[i] && !taken) begin
                    wn[i] = 1'b1;
                    e_ok[i] = 1'b1;
                    claimed.push_back(rb[i]);
                end
            end
        end
        for (int i = 0; i < N; i++) begin
            bit lose;
            lose = hit[i];
            for (int j = 0; j < N; j++)
                if (j != i && wn[j] && rb[j] == mb[i]) lose = 1'b1;
            if (req_valid[i] && !req_is_sc[i]) begin
                mv[i] = 1'b1; mb[i] = rb[i];
            end else if (req_valid[i]) begin
                mv[i] = 1'b0;
            end else if (lose) begin
                mv[i] = 1'b0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "sc_done", sc_done, e_done);
        check(tag, "sc_ok", sc_ok, e_ok);
        check(tag, "mem_we", mem_we, e_ok);
        clr();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin mv[i] = 0; mb[i] = 0; end
        clr();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check("R1", "sc_done", sc_done, '0);
        check("R1", "mem_we", mem_we, '0);
        rst_n = 1'b1;
        step("R1");
        sc(0, 32'h0000_1000); step("R1");

        // R2: link then store at other offset in same block
        ll(0, 32'h0000_1000); step("R2");
        sc(0, 32'h0000_1010); step("R2");
        // R6: second store without new link
        sc(0, 32'h0000_1000); step("R6");
        // R4: different block
        ll(1, 32'h0000_2000); step("R4");
        sc(1, 32'h0000_2040); step("R4");
        // R7: foreign snoop clears
        ll(2, 32'h0000_3000); step("R7");
        snoop(3, 32'h0000_3008); step("R7");
        sc(2, 32'h0000_3000); step("R7");
        // R7: own snoop and other-block snoop ignored
        ll(2, 32'h0000_3000); step("R7");
        snoop(2, 32'h0000_3000); step("R7");
        snoop(1, 32'h0000_9000); step("R7");
        sc(2, 32'h0000_3004); step("R7");
        // R7: snoop same cycle as store
        ll(1, 32'h0000_3000); step("R7");
        sc(1, 32'h0000_3000); snoop(0, 32'h0000_3000); step("R7");
        // R8: winner clears other link
        ll(0, 32'h0000_4000); ll(1, 32'h0000_4020); step("R8");
        sc(0, 32'h0000_4000); step("R8");
        sc(1, 32'h0000_4000); step("R8");
        // R9: same-cycle contest, lowest index wins
        ll(1, 32'h0000_5000); ll(2, 32'h0000_5000); ll(3, 32'h0000_5000); step("R9");
        sc(2, 32'h0000_5000); sc(3, 32'h0000_5000); step("R9");
        sc(1, 32'h0000_5000); step("R9");
        // R10: link in same cycle as clearing snoop
        ll(0, 32'h0000_6000); snoop(1, 32'h0000_6000); step("R10");
        sc(0, 32'h0000_6000); step("R10");
        // R11: re-link replaces old block
        ll(3, 32'h0000_7000); step("R11");
        ll(3, 32'h0000_8000); step("R11");
        sc(3, 32'h0000_7000); step("R11");
        ll(3, 32'h0000_7000); step("R11");
        ll(3, 32'h0000_8000); step("R11");
        sc(3, 32'h0000_8000); step("R11");

        // R3: mixed random traffic over a few colliding blocks
        for (int n = 0; n < 4000; n++) begin
            for (int c = 0; c < N; c++) begin
                int op;
                logic [AW-1:0] a;
                op = int'($urandom_range(0, 2));
                a = 32'h1000_0000 | (AW'($urandom_range(0, 3)) << OW) |
                    AW'($urandom_range(0, 63));
                if (op == 1) ll(c, a);
                else if (op == 2) sc(c, a);
            end
            if ($urandom_range(0, 3) == 0)
                snoop(int'($urandom_range(0, N-1)),
                      32'h1000_0000 | (AW'($urandom_range(0, 3)) << OW));
            step("R3");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule